// File: doc/BRIEF.md
# Word-to-Byte Serial Data Buffer

This block sits between a 32-bit register port and a byte-wide serial shifting engine. It holds one buffer in each direction. On the transmit path, software pushes 32-bit words. The block hands the engine one byte at a time and stops once a programmed byte count has gone out. When the count ends inside a word, the unused lanes of that last word are dropped. On the receive path, the engine delivers bytes and the block gathers them into 32-bit words. A word that is still partial when the engine marks the final byte is pushed with its empty lanes zeroed. Software then reads the receive path back word by word.

Each direction has its own lane-order select. With 0, the first byte of the stream occupies bits [7:0] and the following bytes climb upward. With 1, the first byte occupies bits [31:24] and the following bytes descend. Each buffer holds `DEPTH` words, which is `4*DEPTH` bytes, so one transfer on this path carries at most `4*DEPTH` bytes. The `clr` input empties both buffers, clears the byte counter and both lane pointers, and clears the sticky error flags.

The byte streams use valid/ready handshakes. A byte moves on a clock edge where both valid and ready are high. The source must hold valid and data steady until ready is seen. The word port differs: it behaves like a register access that cannot wait. `wr_ready` shows whether there is space, and a word offered while `wr_ready` is low is lost. In the same way, `rd_ready` is a read strobe, and a strobe while `rd_valid` is low is an underflow and not a wait.

Top module: `spi_word_fifo`

## Requirements
- R1: After reset or a one-cycle `clr`, both buffers are empty with level 0, `tx_ovf` and `rx_udf` are 0, and the next transmitted or received byte uses stream position 0 of a fresh word, even if `clr` arrived in the middle of a word.
- R2: With `tx_order`=0, a word W is emitted on `txb_data` as W[7:0], W[15:8], W[23:16], W[31:24], in that order.
- R3: With `tx_order`=1, a word W is emitted as W[31:24], W[23:16], W[15:8], W[7:0], in that order.
- R4: `txb_valid` rises only while the transmit buffer holds a word and fewer than `tx_len` bytes have gone out since the last `clr`. After byte number `tx_len`, the word holding it is removed and its remaining lanes are discarded. `tx_len`=0 emits nothing.
- R5: A word offered on `wr_valid` while the transmit buffer is full (`wr_ready`=0) is not stored, the level stays at `DEPTH`, and `tx_ovf` goes to 1 on the next cycle and holds until `clr`.
- R6: With `rx_order`=0, received byte i of a word is placed at bits [8*i+7:8*i].
- R7: With `rx_order`=1, received byte i of a word is placed at bits [31-8*i:24-8*i].
- R8: A byte accepted with `rxb_last`=1 closes the word: it is pushed even if fewer than 4 bytes were gathered, with the unfilled lanes zero.
- R9: While the receive buffer is empty, `rd_valid` is 0 and `rd_data` reads 0. A `rd_ready` strobe in that state removes nothing and sets `rx_udf` on the next cycle, and `rx_udf` holds until `clr`.
- R10: `tx_level` and `rx_level` count stored words. The full flags are set at `DEPTH` and the empty flags at 0. `wr_ready` equals not `tx_full`, and `rxb_ready` equals not `rx_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous soft clear of both paths and both flags |
| tx_order | input | 1 | Transmit lane order: 0 first byte in [7:0], 1 first byte in [31:24] |
| rx_order | input | 1 | Receive lane order, same encoding |
| tx_len | input | LEN_W | Bytes to emit in the current transfer (0 to 4*DEPTH) |
| wr_valid | input | 1 | Word write strobe |
| wr_ready | output | 1 | Space available for a word |
| wr_data | input | 32 | Word to transmit |
| txb_valid | output | 1 | Transmit byte available |
| txb_ready | input | 1 | Engine takes the byte |
| txb_data | output | 8 | Transmit byte |
| rxb_valid | input | 1 | Received byte offered |
| rxb_ready | output | 1 | Receive path can accept a byte |
| rxb_data | input | 8 | Received byte |
| rxb_last | input | 1 | Offered byte is the last of the transfer |
| rd_valid | output | 1 | A received word is available |
| rd_ready | input | 1 | Word read strobe |
| rd_data | output | 32 | Head received word, or 0 when empty |
| tx_level | output | LVL_W | Words held for transmit |
| tx_empty | output | 1 | Transmit buffer empty |
| tx_full | output | 1 | Transmit buffer full |
| rx_level | output | LVL_W | Received words held |
| rx_empty | output | 1 | Receive buffer empty |
| rx_full | output | 1 | Receive buffer full |
| tx_ovf | output | 1 | Sticky: a word was dropped at a full transmit buffer |
| rx_udf | output | 1 | Sticky: a word was read from an empty receive buffer |

## Verification
The bench builds the block with the default `DEPTH` of 8 words. With that depth, `tx_len` is 6 bits wide and covers 0 through 32 bytes, and both full conditions can be reached: eight word writes fill the transmit side and thirty-two byte pushes fill the receive side. This makes the dropped-write overflow and the receive back-pressure (`rxb_ready` low) directly observable. The small depth also keeps the walks across byte counts that end mid-word short, including partial final words on both sides under both lane orders.

// File: rtl/spi_wf_pkg.sv
package spi_wf_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = BYTE_W * LANES;

  typedef enum logic {
    LANE_LSB_FIRST = 1'b0,
    LANE_MSB_FIRST = 1'b1
  } lane_order_e;

  // Map stream position within a word to the physical byte lane.
  function automatic logic [1:0] phys_lane(input logic [1:0] seq, input lane_order_e ord);
    return (ord == LANE_MSB_FIRST) ? (2'd3 - seq) : seq;
  endfunction

  function automatic logic [BYTE_W-1:0] get_lane(input logic [WORD_W-1:0] w, input logic [1:0] l);
    return w[BYTE_W*int'(l) +: BYTE_W];
  endfunction

  function automatic logic [WORD_W-1:0] put_lane(input logic [BYTE_W-1:0] b, input logic [1:0] l);
    logic [WORD_W-1:0] r;
    r = '0;
    r[BYTE_W*int'(l) +: BYTE_W] = b;
    return r;
  endfunction
endpackage

// File: rtl/spi_wf_fifo.sv
module spi_wf_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic             push_ok, pop_ok;

  assign empty   = (level == '0);
  assign full    = (level == LVL_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi_wf_tx_unpack.sv
module spi_wf_tx_unpack
  import spi_wf_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [WORD_W-1:0] head,
  input  logic              fifo_empty,
  input  lane_order_e       order,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              byte_ready,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              pop
);
  logic [1:0]       seq;
  logic [LEN_W-1:0] sent;
  logic             fire, final_byte;

  assign byte_valid = !fifo_empty && (sent < xfer_len);
  assign fire       = byte_valid && byte_ready;
  assign final_byte = (LEN_W'(sent + 1'b1) == xfer_len);
  assign pop        = fire && ((seq == 2'd3) || final_byte);
  assign byte_data  = get_lane(head, phys_lane(seq, order));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq  <= '0;
      sent <= '0;
    end else if (clr) begin
      seq  <= '0;
      sent <= '0;
    end else if (fire) begin
      sent <= sent + 1'b1;
      seq  <= pop ? 2'd0 : seq + 1'b1;
    end
  end
endmodule

// File: rtl/spi_wf_rx_pack.sv
module spi_wf_rx_pack
  import spi_wf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_last,
  input  lane_order_e       order,
  input  logic              fifo_full,
  output logic              byte_ready,
  output logic              push,
  output logic [WORD_W-1:0] push_word
);
  logic [WORD_W-1:0] acc;
  logic [1:0]        seq;
  logic              fire;

  assign byte_ready = !fifo_full;
  assign fire       = byte_valid && byte_ready;
  assign push_word  = acc | put_lane(byte_data, phys_lane(seq, order));
  assign push       = fire && ((seq == 2'd3) || byte_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      seq <= '0;
    end else if (clr) begin
      acc <= '0;
      seq <= '0;
    end else if (fire) begin
      if (push) begin
        acc <= '0;
        seq <= '0;
      end else begin
        acc <= push_word;
        seq <= seq + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_word_fifo.sv
module spi_word_fifo
  import spi_wf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int LEN_W = $clog2(DEPTH * LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tx_order,
  input  logic              rx_order,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  output logic              txb_valid,
  input  logic              txb_ready,
  output logic [BYTE_W-1:0] txb_data,
  input  logic              rxb_valid,
  output logic              rxb_ready,
  input  logic [BYTE_W-1:0] rxb_data,
  input  logic              rxb_last,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic [LVL_W-1:0]  tx_level,
  output logic              tx_empty,
  output logic              tx_full,
  output logic [LVL_W-1:0]  rx_level,
  output logic              rx_empty,
  output logic              rx_full,
  output logic              tx_ovf,
  output logic              rx_udf
);
  logic [WORD_W-1:0] tx_head, rx_head, rx_word;
  logic              tx_pop, rx_push;

  spi_wf_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk, .rst_n, .clr,
    .push(wr_valid), .push_data(wr_data), .pop(tx_pop),
    .head(tx_head), .level(tx_level), .empty(tx_empty), .full(tx_full)
  );

  spi_wf_tx_unpack #(.LEN_W(LEN_W)) u_tx_unpack (
    .clk, .rst_n, .clr,
    .head(tx_head), .fifo_empty(tx_empty), .order(lane_order_e'(tx_order)),
    .xfer_len(tx_len), .byte_ready(txb_ready),
    .byte_valid(txb_valid), .byte_data(txb_data), .pop(tx_pop)
  );

  spi_wf_rx_pack u_rx_pack (
    .clk, .rst_n, .clr,
    .byte_valid(rxb_valid), .byte_data(rxb_data), .byte_last(rxb_last),
    .order(lane_order_e'(rx_order)), .fifo_full(rx_full),
    .byte_ready(rxb_ready), .push(rx_push), .push_word(rx_word)
  );

  spi_wf_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk, .rst_n, .clr,
    .push(rx_push), .push_data(rx_word), .pop(rd_ready),
    .head(rx_head), .level(rx_level), .empty(rx_empty), .full(rx_full)
  );

  assign wr_ready = !tx_full;
  assign rd_valid = !rx_empty;
  assign rd_data  = rd_valid ? rx_head : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovf <= 1'b0;
      rx_udf <= 1'b0;
    end else if (clr) begin
      tx_ovf <= 1'b0;
      rx_udf <= 1'b0;
    end else begin
      if (wr_valid && tx_full) tx_ovf <= 1'b1;
      if (rd_ready && rx_empty) rx_udf <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_word_fifo_chk.sv
module spi_word_fifo_chk #(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             txb_valid,
  input logic             tx_empty,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [31:0]      rd_data,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_empty,
  input logic             tx_ovf,
  input logic             rx_udf
);
  assert_clr_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tx_empty && rx_empty && !tx_ovf && !rx_udf));

  assert_no_byte_from_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    txb_valid |-> !tx_empty);

  assert_ovf_raised_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !clr) |=> tx_ovf);

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf && !clr) |=> tx_ovf);

  assert_full_level_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !clr) |=> (tx_level <= LVL_W'(DEPTH)));

  assert_udf_raised_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_valid && !clr) |=> rx_udf);

  assert_empty_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> (rd_data == 32'd0));

  assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));
endmodule

bind spi_word_fifo spi_word_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr),
  .wr_valid(wr_valid), .wr_ready(wr_ready),
  .txb_valid(txb_valid), .tx_empty(tx_empty),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .tx_level(tx_level), .rx_level(rx_level), .rx_empty(rx_empty),
  .tx_ovf(tx_ovf), .rx_udf(rx_udf)
);

// File: tb/test_spi_word_fifo.sv
`timescale 1ns/1ps
module test_spi_word_fifo;
  localparam int DEPTH = 8;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int LEN_W = $clog2(DEPTH * 4 + 1);

  typedef struct packed {
    logic        order;
    logic [31:0] word;
    logic [31:0] stream; // stream byte k in [8k+7:8k]
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h44332211, 32'h44332211},
    '{1'b1, 32'h44332211, 32'h11223344},
    '{1'b0, 32'hDEADBEEF, 32'hDEADBEEF},
    '{1'b1, 32'hDEADBEEF, 32'hEFBEADDE},
    '{1'b1, 32'h00FF00A5, 32'hA500FF00},
    '{1'b0, 32'h80000001, 32'h80000001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic tx_order = 1'b0, rx_order = 1'b0;
  logic [LEN_W-1:0] tx_len = '0;
  logic wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic txb_ready = 1'b0;
  logic rxb_valid = 1'b0, rxb_last = 1'b0;
  logic [7:0] rxb_data = '0;
  logic rd_ready = 1'b0;
  logic wr_ready, txb_valid, rxb_ready, rd_valid;
  logic [7:0] txb_data;
  logic [31:0] rd_data;
  logic [LVL_W-1:0] tx_level, rx_level;
  logic tx_empty, tx_full, rx_empty, rx_full, tx_ovf, rx_udf;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_word_fifo #(.DEPTH(DEPTH)) i_spi_word_fifo (
    .clk, .rst_n, .clr, .tx_order, .rx_order, .tx_len,
    .wr_valid, .wr_ready, .wr_data,
    .txb_valid, .txb_ready, .txb_data,
    .rxb_valid, .rxb_ready, .rxb_data, .rxb_last,
    .rd_valid, .rd_ready, .rd_data,
    .tx_level, .tx_empty, .tx_full, .rx_level, .rx_empty, .rx_full,
    .tx_ovf, .rx_udf
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic do_clr();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic put_word(input logic [31:0] w);
    wr_valid = 1'b1; wr_data = w; @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic take_byte(input string req, input logic [7:0] exp);
    chk(req, {31'd0, txb_valid}, 32'd1);
    chk(req, {24'd0, txb_data}, {24'd0, exp});
    txb_ready = 1'b1; @(negedge clk); txb_ready = 1'b0;
  endtask

  task automatic give_byte(input logic [7:0] b, input logic last);
    rxb_valid = 1'b1; rxb_data = b; rxb_last = last;
    @(negedge clk);
    rxb_valid = 1'b0; rxb_last = 1'b0;
  endtask

  task automatic read_word(input string req, input logic vexp, input logic [31:0] exp);
    chk(req, {31'd0, rd_valid}, {31'd0, vexp});
    chk(req, rd_data, exp);
    rd_ready = 1'b1; @(negedge clk); rd_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10: reset state
    chk("R1 tx_empty", {31'd0, tx_empty}, 32'd1);
    chk("R1 rx_empty", {31'd0, rx_empty}, 32'd1);
    chk("R1 levels", {16'd0, 8'(tx_level), 8'(rx_level)}, 32'd0);
    chk("R1 flags", {30'd0, tx_ovf, rx_udf}, 32'd0);
    chk("R10 wr_ready", {31'd0, wr_ready}, 32'd1);
    chk("R10 rxb_ready", {31'd0, rxb_ready}, 32'd1);
    chk("R9 rd_data empty", rd_data, 32'd0);

    // Vector table: R2/R3 transmit order, R6/R7 receive order
    for (int v = 0; v < NV; v++) begin
      tx_order = VECS[v].order;
      rx_order = VECS[v].order;
      tx_len = LEN_W'(4);
      do_clr();
      put_word(VECS[v].word);
      for (int k = 0; k < 4; k++)
        take_byte(VECS[v].order ? "R3 tx byte" : "R2 tx byte", VECS[v].stream[8*k +: 8]);
      chk("R4 word removed", {31'd0, tx_empty}, 32'd1);
      for (int k = 0; k < 4; k++)
        give_byte(VECS[v].stream[8*k +: 8], k == 3);
      read_word(VECS[v].order ? "R7 rx word" : "R6 rx word", 1'b1, VECS[v].word);
    end

    // R4: count ends mid-word, remaining lanes dropped
    tx_order = 1'b0; tx_len = LEN_W'(6);
    do_clr();
    put_word(32'h04030201);
    put_word(32'h08070605);
    for (int k = 1; k <= 6; k++) take_byte("R4 tx len 6", 8'(k));
    chk("R4 valid after count", {31'd0, txb_valid}, 32'd0);
    chk("R4 level after count", {24'd0, 8'(tx_level)}, 32'd0);

    // R4: zero length emits nothing
    tx_len = '0;
    do_clr();
    put_word(32'hCAFEF00D);
    chk("R4 len 0 no valid", {31'd0, txb_valid}, 32'd0);
    chk("R4 len 0 word kept", {24'd0, 8'(tx_level)}, 32'd1);

    // R5 / R10: overflow on full transmit buffer
    tx_len = LEN_W'(32);
    do_clr();
    for (int k = 0; k < DEPTH; k++) put_word(32'h10 + k);
    chk("R10 tx_full", {31'd0, tx_full}, 32'd1);
    chk("R10 wr_ready low", {31'd0, wr_ready}, 32'd0);
    chk("R5 no ovf yet", {31'd0, tx_ovf}, 32'd0);
    put_word(32'hBAD0BAD0);
    chk("R5 ovf set", {31'd0, tx_ovf}, 32'd1);
    chk("R5 level kept", {24'd0, 8'(tx_level)}, DEPTH);
    @(negedge clk);
    chk("R5 ovf sticky", {31'd0, tx_ovf}, 32'd1);
    take_byte("R5 head intact", 8'h10);

    // R1: clr mid-word resets transmit lane pointer
    tx_len = LEN_W'(4);
    do_clr();
    chk("R1 ovf cleared", {31'd0, tx_ovf}, 32'd0);
    put_word(32'h44332211);
    take_byte("R1 tx first", 8'h11);
    do_clr();
    put_word(32'hA4A3A2A1);
    take_byte("R1 tx lane reset", 8'hA1);

    // R8: partial final words, both orders
    rx_order = 1'b0;
    do_clr();
    give_byte(8'hAA, 1'b0); give_byte(8'hBB, 1'b0); give_byte(8'hCC, 1'b1);
    read_word("R8 partial lsb", 1'b1, 32'h00CCBBAA);
    rx_order = 1'b1;
    give_byte(8'hAA, 1'b0); give_byte(8'hBB, 1'b1);
    read_word("R8 partial msb", 1'b1, 32'hAABB0000);
    give_byte(8'h5A, 1'b1);
    read_word("R8 single byte msb", 1'b1, 32'h5A000000);

    // R1: clr mid-word resets receive accumulation
    rx_order = 1'b0;
    give_byte(8'hEE, 1'b0); give_byte(8'hEE, 1'b0);
    do_clr();
    for (int k = 1; k <= 4; k++) give_byte(8'(k), 1'b0);
    read_word("R1 rx lane reset", 1'b1, 32'h04030201);

    // R10: receive side fills and back-pressures
    do_clr();
    for (int k = 0; k < 4 * DEPTH; k++) give_byte(8'(k), 1'b0);
    chk("R10 rx_full", {31'd0, rx_full}, 32'd1);
    chk("R10 rxb_ready low", {31'd0, rxb_ready}, 32'd0);
    chk("R10 rx_level", {24'd0, 8'(rx_level)}, DEPTH);
    give_byte(8'hFF, 1'b1);
    chk("R10 level unchanged", {24'd0, 8'(rx_level)}, DEPTH);
    read_word("R6 first of full", 1'b1, 32'h03020100);

    // R9: underflow
    do_clr();
    read_word("R9 empty read", 1'b0, 32'd0);
    chk("R9 udf set", {31'd0, rx_udf}, 32'd1);
    chk("R9 level stays 0", {24'd0, 8'(rx_level)}, 32'd0);
    do_clr();
    chk("R1 udf cleared", {31'd0, rx_udf}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule